// File: doc/BRIEF.md
# Switch Egress Port-Mask Resolver

This block takes the final forwarding decision for one frame in a five-port store-and-forward switch. The frame must already be fully stored. The block receives the ingress port and the destination mask from the address and VLAN lookup. It also receives the frame's status flags, its byte length and whether it carries a VLAN tag. From these it produces either the set of egress ports that get a copy of the frame, or a drop with a coded reason.

The lookup mask is refined in a fixed order. Spanning-tree filtering comes first, then the multicast-snooping redirect, then traffic mirroring, and last the VLAN membership filter. In parallel, a set of drop rules is evaluated. These cover receive errors, flow-control pause frames, length out of range, and frames whose only destination is the port they came from. An empty refined mask is also a drop. One decision is accepted per valid/ready handshake, and its result is presented in a register one clock later.

Top module: `fwd_resolver`

## Requirements
- R1: All outputs are zero during reset. `reqReady` rises on the first clock edge after reset is released. An accepted request (`reqValid` and `reqReady` high at a clock edge) raises `resValid` for the following cycle only. Without a handshake, `resValid` stays low.
- R2: If any bit of `errFlags` is set, the frame is dropped with reason 1, ahead of every other rule. The bits are: bit 0 framing, bit 1 checksum, bit 2 alignment, bit 3 illegal size.
- R3: A frame marked by `isPause` with no error is dropped with reason 2.
- R4: With no error and no pause, a frame is dropped with reason 3 when its length is below 64 bytes. It is also dropped with reason 3 when its length exceeds the limit. The limit is 1536 bytes with `longFrameEn` low and 1916 bytes with it high.
- R5: When `hasTag` is high, the length limit of R4 is raised by 4 bytes.
- R6: A frame that passes R2 to R5 is dropped with reason 4 when `lookupMask` is exactly the one-hot bit of its ingress port.
- R7: A mask bit survives spanning-tree filtering only when the port is set in `stpFwdMask`. The ingress port's bit is always cleared.
- R8: With `snoopEn` and `isIgmp` both high, the mask after R7 is replaced by the one-hot bit of `snoopPort`. The ingress port is still cleared from it.
- R9: With `mirrorEn` high, the bit of `mirrorPort` is ORed into the mask when the ingress port is set in `mirrorRxMask`. The same happens when any port of the mask after R8 is set in `mirrorTxMask`.
- R10: The mask after R9 is ANDed with `vlanMemberMask`, and that result is the forwarded mask.
- R11: If no drop rule applies and the R10 mask is zero, the frame is dropped with reason 5. A dropped result shows `resDrop` high and a zero mask. A forwarded result shows `resDrop` low, reason 0 and a non-zero mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Decision request valid |
| reqReady | output | 1 | Block can accept a request |
| ingressPort | input | 3 | Port the frame arrived on (0 to 4) |
| lookupMask | input | 5 | First-stage destination mask |
| errFlags | input | 4 | Framing, checksum, alignment, illegal-size flags |
| isPause | input | 1 | Frame is a flow-control pause frame |
| isIgmp | input | 1 | Frame is a multicast-membership control frame |
| frameLen | input | 12 | Frame length in bytes |
| hasTag | input | 1 | Frame carries a VLAN tag |
| longFrameEn | input | 1 | Select the larger length limit |
| stpFwdMask | input | 5 | Ports in spanning-tree forwarding state |
| snoopEn | input | 1 | Enable multicast-snooping redirect |
| snoopPort | input | 3 | Port receiving redirected control frames |
| mirrorEn | input | 1 | Enable mirroring |
| mirrorPort | input | 3 | Mirror destination port |
| mirrorRxMask | input | 5 | Ports whose received traffic is mirrored |
| mirrorTxMask | input | 5 | Ports whose transmitted traffic is mirrored |
| vlanMemberMask | input | 5 | VLAN membership of the frame's VLAN |
| resValid | output | 1 | Result valid, one cycle |
| resMask | output | 5 | Final egress mask |
| resDrop | output | 1 | Frame dropped |
| resReason | output | 3 | Drop reason code |

## Verification
The assertions assume that `ingressPort`, `snoopPort` and `mirrorPort` always name one of the five ports. They also assume that request fields are meaningful only in the cycle of a handshake. The no-ingress-in-mask property is only claimed while mirroring is off, because a mirror port may legally be the ingress port. The bench draws every port index from 0 to 4 and changes request fields only between clock edges. It combines directed corner cases, including lengths exactly at each limit and stacked drop causes, with random requests that mix idle and back-to-back cycles.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;

  typedef enum logic [2:0] {
    RSN_NONE  = 3'd0,
    RSN_ERROR = 3'd1,
    RSN_PAUSE = 3'd2,
    RSN_SIZE  = 3'd3,
    RSN_LOCAL = 3'd4,
    RSN_EMPTY = 3'd5
  } dropReason_e;

  typedef struct packed {
    logic capture;
    logic ready;
  } ctrlStrobe_t;

endpackage

// File: rtl/fwd_ctrl.sv
`timescale 1ns/1ps
module fwd_ctrl
  import fwd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output ctrlStrobe_t strobe
);

  logic readyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= 1'b1;
  end

  always_comb begin
    strobe.ready   = readyQ;
    strobe.capture = reqValid & readyQ;
  end

  assign reqReady = readyQ;

endmodule

// File: rtl/fwd_len_check.sv
`timescale 1ns/1ps
module fwd_len_check #(
  parameter int LEN_W     = 12,
  parameter int MIN_LEN   = 64,
  parameter int MAX_STD   = 1536,
  parameter int MAX_EXT   = 1916,
  parameter int TAG_BYTES = 4
) (
  input  logic [LEN_W-1:0] frameLen,
  input  logic             hasTag,
  input  logic             longFrameEn,
  output logic             sizeBad
);

  localparam int LIM_W = LEN_W + 1;

  logic [LIM_W-1:0] baseLimit;
  logic [LIM_W-1:0] tagAllow;
  logic [LIM_W-1:0] upperLimit;
  logic [LIM_W-1:0] lenWide;

  assign lenWide    = {1'b0, frameLen};
  assign baseLimit  = longFrameEn ? LIM_W'(MAX_EXT) : LIM_W'(MAX_STD);
  assign tagAllow   = hasTag ? LIM_W'(TAG_BYTES) : '0;
  assign upperLimit = baseLimit + tagAllow;
  assign sizeBad    = (lenWide < LIM_W'(MIN_LEN)) || (lenWide > upperLimit);

endmodule

// File: rtl/fwd_datapath.sv
`timescale 1ns/1ps
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int PORT_W    = 3,
  parameter int LEN_W     = 12,
  parameter int ERR_W     = 4,
  parameter int MIN_LEN   = 64,
  parameter int MAX_STD   = 1536,
  parameter int MAX_EXT   = 1916,
  parameter int TAG_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [PORT_W-1:0]    ingressPort,
  input  logic [NUM_PORTS-1:0] lookupMask,
  input  logic [ERR_W-1:0]     errFlags,
  input  logic                 isPause,
  input  logic                 isIgmp,
  input  logic [LEN_W-1:0]     frameLen,
  input  logic                 hasTag,
  input  logic                 longFrameEn,
  input  logic [NUM_PORTS-1:0] stpFwdMask,
  input  logic                 snoopEn,
  input  logic [PORT_W-1:0]    snoopPort,
  input  logic                 mirrorEn,
  input  logic [PORT_W-1:0]    mirrorPort,
  input  logic [NUM_PORTS-1:0] mirrorRxMask,
  input  logic [NUM_PORTS-1:0] mirrorTxMask,
  input  logic [NUM_PORTS-1:0] vlanMemberMask,
  output logic                 resValid,
  output logic [NUM_PORTS-1:0] resMask,
  output logic                 resDrop,
  output logic [2:0]           resReason
);

  logic [NUM_PORTS-1:0] ingBit;
  logic [NUM_PORTS-1:0] snoopBit;
  logic [NUM_PORTS-1:0] mirrorBit;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_portDecode
    assign ingBit[p]    = (ingressPort == PORT_W'(p));
    assign snoopBit[p]  = (snoopPort   == PORT_W'(p));
    assign mirrorBit[p] = (mirrorPort  == PORT_W'(p));
  end

  logic [NUM_PORTS-1:0] stpMask;
  logic [NUM_PORTS-1:0] igmpMask;
  logic [NUM_PORTS-1:0] mirMask;
  logic [NUM_PORTS-1:0] finalMask;
  logic                 rxHit;
  logic                 txHit;

  assign stpMask   = lookupMask & stpFwdMask & ~ingBit;
  assign igmpMask  = (snoopEn && isIgmp) ? (snoopBit & ~ingBit) : stpMask;
  assign rxHit     = |(ingBit & mirrorRxMask);
  assign txHit     = |(igmpMask & mirrorTxMask);
  assign mirMask   = (mirrorEn && (rxHit || txHit)) ? (igmpMask | mirrorBit) : igmpMask;
  assign finalMask = mirMask & vlanMemberMask;

  logic sizeBad;
  logic isLocal;

  fwd_len_check #(
    .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_STD(MAX_STD),
    .MAX_EXT(MAX_EXT), .TAG_BYTES(TAG_BYTES)
  ) lenChk_i (
    .frameLen(frameLen), .hasTag(hasTag), .longFrameEn(longFrameEn),
    .sizeBad(sizeBad)
  );

  assign isLocal = (lookupMask == ingBit);

  dropReason_e reasonNext;

  always_comb begin
    if (|errFlags)          reasonNext = RSN_ERROR;
    else if (isPause)       reasonNext = RSN_PAUSE;
    else if (sizeBad)       reasonNext = RSN_SIZE;
    else if (isLocal)       reasonNext = RSN_LOCAL;
    else if (~|finalMask)   reasonNext = RSN_EMPTY;
    else                    reasonNext = RSN_NONE;
  end

  logic                 validQ;
  logic [NUM_PORTS-1:0] maskQ;
  logic                 dropQ;
  dropReason_e          reasonQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ  <= 1'b0;
      maskQ   <= '0;
      dropQ   <= 1'b0;
      reasonQ <= RSN_NONE;
    end else begin
      validQ <= strobe.capture;
      if (strobe.capture) begin
        dropQ   <= (reasonNext != RSN_NONE);
        reasonQ <= reasonNext;
        maskQ   <= (reasonNext == RSN_NONE) ? finalMask : '0;
      end
    end
  end

  assign resValid  = validQ;
  assign resMask   = maskQ;
  assign resDrop   = dropQ;
  assign resReason = reasonQ;

endmodule

// File: rtl/fwd_resolver.sv
`timescale 1ns/1ps
module fwd_resolver
  import fwd_pkg::*;
#(
  parameter  int NUM_PORTS = 5,
  parameter  int LEN_W     = 12,
  parameter  int ERR_W     = 4,
  parameter  int MIN_LEN   = 64,
  parameter  int MAX_STD   = 1536,
  parameter  int MAX_EXT   = 1916,
  parameter  int TAG_BYTES = 4,
  localparam int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [PORT_W-1:0]    ingressPort,
  input  logic [NUM_PORTS-1:0] lookupMask,
  input  logic [ERR_W-1:0]     errFlags,
  input  logic                 isPause,
  input  logic                 isIgmp,
  input  logic [LEN_W-1:0]     frameLen,
  input  logic                 hasTag,
  input  logic                 longFrameEn,
  input  logic [NUM_PORTS-1:0] stpFwdMask,
  input  logic                 snoopEn,
  input  logic [PORT_W-1:0]    snoopPort,
  input  logic                 mirrorEn,
  input  logic [PORT_W-1:0]    mirrorPort,
  input  logic [NUM_PORTS-1:0] mirrorRxMask,
  input  logic [NUM_PORTS-1:0] mirrorTxMask,
  input  logic [NUM_PORTS-1:0] vlanMemberMask,
  output logic                 resValid,
  output logic [NUM_PORTS-1:0] resMask,
  output logic                 resDrop,
  output logic [2:0]           resReason
);

  ctrlStrobe_t strobe;

  fwd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqReady(reqReady), .strobe(strobe)
  );

  fwd_datapath #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .LEN_W(LEN_W), .ERR_W(ERR_W),
    .MIN_LEN(MIN_LEN), .MAX_STD(MAX_STD), .MAX_EXT(MAX_EXT), .TAG_BYTES(TAG_BYTES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ingressPort(ingressPort), .lookupMask(lookupMask), .errFlags(errFlags),
    .isPause(isPause), .isIgmp(isIgmp), .frameLen(frameLen), .hasTag(hasTag),
    .longFrameEn(longFrameEn), .stpFwdMask(stpFwdMask), .snoopEn(snoopEn),
    .snoopPort(snoopPort), .mirrorEn(mirrorEn), .mirrorPort(mirrorPort),
    .mirrorRxMask(mirrorRxMask), .mirrorTxMask(mirrorTxMask),
    .vlanMemberMask(vlanMemberMask),
    .resValid(resValid), .resMask(resMask), .resDrop(resDrop), .resReason(resReason)
  );

endmodule

// File: rtl/fwd_resolver_chk.sv
`timescale 1ns/1ps
module fwd_resolver_chk #(
  parameter  int NUM_PORTS = 5,
  parameter  int LEN_W     = 12,
  parameter  int ERR_W     = 4,
  parameter  int MIN_LEN   = 64,
  localparam int PORT_W    = $clog2(NUM_PORTS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic [PORT_W-1:0]    ingressPort,
  input logic [NUM_PORTS-1:0] lookupMask,
  input logic [ERR_W-1:0]     errFlags,
  input logic                 isPause,
  input logic                 isIgmp,
  input logic [LEN_W-1:0]     frameLen,
  input logic                 hasTag,
  input logic                 longFrameEn,
  input logic [NUM_PORTS-1:0] stpFwdMask,
  input logic                 snoopEn,
  input logic [PORT_W-1:0]    snoopPort,
  input logic                 mirrorEn,
  input logic [PORT_W-1:0]    mirrorPort,
  input logic [NUM_PORTS-1:0] mirrorRxMask,
  input logic [NUM_PORTS-1:0] mirrorTxMask,
  input logic [NUM_PORTS-1:0] vlanMemberMask,
  input logic                 resValid,
  input logic [NUM_PORTS-1:0] resMask,
  input logic                 resDrop,
  input logic [2:0]           resReason
);

  logic                 hs;
  logic [NUM_PORTS-1:0] ingOneHot;

  assign hs        = reqValid && reqReady;
  assign ingOneHot = NUM_PORTS'(1) << ingressPort;

  assert_result_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    hs |=> resValid);

  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rstN)
    !hs |=> !resValid);

  assert_error_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hs && (|errFlags)) |=> (resDrop && resReason == 3'd1));

  assert_pause_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hs && !(|errFlags) && isPause) |=> (resDrop && resReason == 3'd2));

  assert_runt_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hs && !(|errFlags) && !isPause && (frameLen < LEN_W'(MIN_LEN)))
      |=> (resDrop && resReason == 3'd3));

  assert_ingress_removed_R7: assert property (@(posedge clk) disable iff (!rstN)
    (hs && !mirrorEn) |=> ((resMask & $past(ingOneHot)) == '0));

  assert_vlan_subset_R10: assert property (@(posedge clk) disable iff (!rstN)
    hs |=> ((resMask & ~$past(vlanMemberMask)) == '0));

  assert_drop_clears_mask_R11: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resDrop) |-> (resMask == '0 && resReason != 3'd0));

  assert_forward_nonempty_R11: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resDrop) |-> (resMask != '0 && resReason == 3'd0));

endmodule

bind fwd_resolver fwd_resolver_chk chk_i (.*);

// File: tb/fwd_resolver_tb_top.sv
`timescale 1ns/1ps
module fwd_resolver_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [2:0] ingressPort = '0;
  logic [4:0] lookupMask = '0;
  logic [3:0] errFlags = '0;
  logic       isPause = 1'b0;
  logic       isIgmp = 1'b0;
  logic [11:0] frameLen = 12'd100;
  logic       hasTag = 1'b0;
  logic       longFrameEn = 1'b0;
  logic [4:0] stpFwdMask = 5'b11111;
  logic       snoopEn = 1'b0;
  logic [2:0] snoopPort = '0;
  logic       mirrorEn = 1'b0;
  logic [2:0] mirrorPort = '0;
  logic [4:0] mirrorRxMask = '0;
  logic [4:0] mirrorTxMask = '0;
  logic [4:0] vlanMemberMask = 5'b11111;
  logic       resValid;
  logic [4:0] resMask;
  logic       resDrop;
  logic [2:0] resReason;

  int checks = 0;
  int errors = 0;
  bit expReady = 1'b0;

  always #10 clk = ~clk;

  fwd_resolver dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Behavioural expectation: {drop, reason[2:0], mask[4:0]}
  function automatic logic [8:0] model();
    int limit;
    logic [4:0] ing, m;
    ing   = 5'b1 << ingressPort;
    limit = (longFrameEn ? 1916 : 1536) + (hasTag ? 4 : 0);
    m = lookupMask & stpFwdMask & ~ing;
    if (snoopEn && isIgmp) m = (5'b1 << snoopPort) & ~ing;
    if (mirrorEn && (mirrorRxMask[ingressPort] || (m & mirrorTxMask) != 0))
      m = m | (5'b1 << mirrorPort);
    m = m & vlanMemberMask;
    if (errFlags != 0)                                      return {1'b1, 3'd1, 5'd0};
    if (isPause)                                            return {1'b1, 3'd2, 5'd0};
    if (int'(frameLen) < 64 || int'(frameLen) > limit)      return {1'b1, 3'd3, 5'd0};
    if (lookupMask == ing)                                  return {1'b1, 3'd4, 5'd0};
    if (m == 0)                                             return {1'b1, 3'd5, 5'd0};
    return {1'b0, 3'd0, m};
  endfunction

  function automatic string tagFor(input logic [8:0] e);
    case (e[7:5])
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R6";
      3'd5: return "R11";
      default: return "R10";
    endcase
  endfunction

  // One clock: inputs are already set; compare result at the next falling edge
  task automatic step(input string tag);
    logic [8:0] e;
    bit acc;
    chk("R1 ready", int'(reqReady), int'(expReady));
    acc = reqValid && expReady;
    e   = model();
    @(negedge clk);
    chk({tag, " valid"}, int'(resValid), int'(acc));
    if (acc) chk(tag, int'({resDrop, resReason, resMask}), int'(e));
    expReady = 1'b1;
  endtask

  task automatic defaults();
    reqValid = 1'b1; ingressPort = 3'd0; lookupMask = 5'b00110; errFlags = '0;
    isPause = 0; isIgmp = 0; frameLen = 12'd100; hasTag = 0; longFrameEn = 0;
    stpFwdMask = 5'b11111; snoopEn = 0; snoopPort = 3'd4; mirrorEn = 0;
    mirrorPort = 3'd3; mirrorRxMask = '0; mirrorTxMask = '0; vlanMemberMask = 5'b11111;
  endtask

  task automatic one(input string tag);
    step(tag);
    reqValid = 1'b0;
    step("R1 idle");
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(resValid), 0);
    chk("R1 reset mask", int'(resMask), 0);
    chk("R1 reset drop", int'({resDrop, resReason}), 0);
    chk("R1 reset ready", int'(reqReady), 0);
    rstN = 1'b1;
    reqValid = 1'b1;            // not accepted: ready still low this cycle
    step("R1 first");
    reqValid = 1'b0;
    step("R1 idle");

    defaults(); one("R10 basic");
    defaults(); stpFwdMask = 5'b11011; one("R7 stp block");
    defaults(); ingressPort = 3'd1; lookupMask = 5'b00111; one("R7 ingress strip");
    defaults(); ingressPort = 3'd3; lookupMask = 5'b01000; one("R6 local");
    for (int b = 0; b < 4; b++) begin
      defaults(); errFlags = 4'b1 << b; one("R2 err bit");
    end
    defaults(); errFlags = 4'b0010; isPause = 1; frameLen = 12'd10; one("R2 priority");
    defaults(); isPause = 1; one("R3 pause");
    defaults(); isPause = 1; frameLen = 12'd20; one("R3 over size");
    defaults(); frameLen = 12'd63; one("R4 63");
    defaults(); frameLen = 12'd64; one("R4 64");
    defaults(); frameLen = 12'd1536; one("R4 1536");
    defaults(); frameLen = 12'd1537; one("R4 1537");
    defaults(); longFrameEn = 1; frameLen = 12'd1916; one("R4 1916");
    defaults(); longFrameEn = 1; frameLen = 12'd1917; one("R4 1917");
    defaults(); hasTag = 1; frameLen = 12'd1540; one("R5 1540 tag");
    defaults(); hasTag = 1; frameLen = 12'd1541; one("R5 1541 tag");
    defaults(); hasTag = 1; longFrameEn = 1; frameLen = 12'd1920; one("R5 1920 tag");
    defaults(); ingressPort = 3'd3; lookupMask = 5'b01000; frameLen = 12'd30; one("R4 before local");
    defaults(); snoopEn = 1; isIgmp = 1; one("R8 redirect");
    defaults(); snoopEn = 1; isIgmp = 1; ingressPort = 3'd4; one("R8 from snoop port");
    defaults(); snoopEn = 0; isIgmp = 1; one("R8 disabled");
    defaults(); mirrorEn = 1; mirrorRxMask = 5'b00001; lookupMask = 5'b00010; one("R9 rx mirror");
    defaults(); mirrorEn = 1; mirrorTxMask = 5'b00010; lookupMask = 5'b00010; one("R9 tx mirror");
    defaults(); mirrorEn = 1; mirrorTxMask = 5'b10000; lookupMask = 5'b00010; one("R9 no match");
    defaults(); vlanMemberMask = 5'b11101; one("R10 vlan trim");
    defaults(); vlanMemberMask = 5'b11001; one("R11 empty");
    defaults(); stpFwdMask = 5'b00001; one("R11 stp empty");
    // back-to-back handshakes
    defaults(); step("R1 b2b a");
    lookupMask = 5'b11000; step("R1 b2b b");
    reqValid = 1'b0; step("R1 idle");

    for (int n = 0; n < 600; n++) begin
      logic [8:0] e;
      reqValid     = ($urandom_range(0, 3) != 0);
      ingressPort  = 3'($urandom_range(0, 4));
      lookupMask   = 5'($urandom);
      errFlags     = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'd0;
      isPause      = ($urandom_range(0, 9) == 0);
      isIgmp       = ($urandom_range(0, 3) == 0);
      case ($urandom_range(0, 3))
        0: frameLen = 12'($urandom_range(50, 80));
        1: frameLen = 12'($urandom_range(1530, 1545));
        2: frameLen = 12'($urandom_range(1910, 1925));
        default: frameLen = 12'($urandom_range(64, 1500));
      endcase
      hasTag       = 1'($urandom);
      longFrameEn  = 1'($urandom);
      stpFwdMask   = 5'($urandom);
      snoopEn      = 1'($urandom);
      snoopPort    = 3'($urandom_range(0, 4));
      mirrorEn     = 1'($urandom);
      mirrorPort   = 3'($urandom_range(0, 4));
      mirrorRxMask = 5'($urandom);
      mirrorTxMask = 5'($urandom);
      vlanMemberMask = 5'($urandom) | 5'($urandom);
      e = model();
      step(tagFor(e));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule